// File: doc/BRIEF.md
# Line-Address Feistel Cipher

This block is a keyed, reversible permutation of cache line addresses. A 40-bit physical line address enters with an 80-bit key and a direction bit. Two clock edges later the block returns a 40-bit scrambled line address. The cache uses the scrambled address to pick a set, so lines that would share a set in the plain mapping end up spread over many sets. The same hardware also runs in the reverse direction. When a dirty victim is evicted, its scrambled address goes back through the block to recover the physical address for the writeback.

The cipher is a four-round balanced Feistel network on two 20-bit halves. Each round function substitutes every nibble through a fixed 4-bit S-box, spreads the bits with a fixed permutation and XORs in a 20-bit round key. Rounds one and two are evaluated before a pipeline register and rounds three and four after it. A new address is accepted on every cycle. The key and direction are captured together with each address, so neighbouring requests may use different keys.

Top module: `lac_addr_cipher`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_addr` is all zeros.
- R2: An address taken with `in_valid` high at clock edge n gives `out_valid` high after edge n+2, with exactly two cycles of latency. One address is accepted per cycle, back to back. `out_valid` is never high without a matching input.
- R3: Encryption (`in_decrypt`=0) sets L = `in_addr[39:20]` and R = `in_addr[19:0]`. Round i (i = 0,1,2,3) uses round key `in_key[20*i+19:20*i]` and maps (L,R) to (R, L xor F(R, key)). The result is `out_addr` = {R, L} after the fourth round.
- R4: F(R, key) is computed in three steps. First, each nibble R[4j+3:4j] is replaced through the S-box table 0→C, 1→5, 2→6, 3→B, 4→9, 5→0, 6→A, 7→D, 8→3, 9→E, A→F, B→8, C→4, D→7, E→1, F→2 (hex). Second, bit b of the permuted word is bit (7*b mod 20) of the substituted word. Third, the permuted word is XORed with the round key.
- R5: Decryption (`in_decrypt`=1) runs the same four rounds with the round keys in the order 3,2,1,0. For any key and any x, decrypting the encryption of x under that key returns x.
- R6: Each address is transformed with the key and direction present on the same cycle as its `in_valid`. Key or direction values on other cycles have no effect on it.
- R7: `out_addr` keeps its last value on every cycle where no new result completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address strobe for this cycle |
| in_decrypt | input | 1 | 0 encrypts, 1 decrypts |
| in_key | input | 80 | Cipher key, four 20-bit round keys |
| in_addr | input | 40 | Line address to transform |
| out_valid | output | 1 | Result strobe, two cycles after the input |
| out_addr | output | 40 | Transformed line address |

## Verification
A fault in the first stage, such as a wrong S-box entry, a misrouted permutation bit or a swapped round key, changes nearly every output bit. It shows on `out_addr` two cycles after the first address that exercises it. Wrong key or direction capture in the pipeline register shows only when the key or direction changes between neighbouring requests. For that reason the random stimulus changes them on every cycle. A broken valid or hold path shows on `out_valid` or on a held `out_addr` in the cycle after the fault. The encrypt-then-decrypt round trip catches any loss of invertibility, with no reference model involved.

// File: rtl/lac_pkg.sv
package lac_pkg;

    localparam int unsigned NIB_W = 4;

    // Fixed 4-bit substitution, a bijection on 0..15
    function automatic logic [NIB_W-1:0] lac_sbox(input logic [NIB_W-1:0] v);
        logic [NIB_W-1:0] s;
        case (v)
            4'h0: s = 4'hC;
            4'h1: s = 4'h5;
            4'h2: s = 4'h6;
            4'h3: s = 4'hB;
            4'h4: s = 4'h9;
            4'h5: s = 4'h0;
            4'h6: s = 4'hA;
            4'h7: s = 4'hD;
            4'h8: s = 4'h3;
            4'h9: s = 4'hE;
            4'hA: s = 4'hF;
            4'hB: s = 4'h8;
            4'hC: s = 4'h4;
            4'hD: s = 4'h7;
            4'hE: s = 4'h1;
            default: s = 4'h2;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lac_round_fn.sv
module lac_round_fn #(
    parameter int unsigned HALF_W = 20,
    parameter int unsigned STRIDE = 7
) (
    input  logic [HALF_W-1:0] half_i,
    input  logic [HALF_W-1:0] rkey_i,
    output logic [HALF_W-1:0] mix_o
);
    import lac_pkg::*;

    localparam int unsigned NIBS = HALF_W / NIB_W;

    logic [HALF_W-1:0] sub_w;
    logic [HALF_W-1:0] perm_w;

    // substitution layer
    for (genvar j = 0; j < NIBS; j++) begin : g_sub
        assign sub_w[j*NIB_W +: NIB_W] = lac_sbox(half_i[j*NIB_W +: NIB_W]);
    end

    // fixed bit permutation: stride must be coprime to HALF_W
    for (genvar b = 0; b < HALF_W; b++) begin : g_perm
        localparam int unsigned SRC = (b * STRIDE) % HALF_W;
        assign perm_w[b] = sub_w[SRC];
    end

    assign mix_o = perm_w ^ rkey_i;

endmodule

// File: rtl/lac_stage.sv
module lac_stage #(
    parameter int unsigned HALF_W = 20,
    parameter int unsigned NR     = 2,
    parameter int unsigned STRIDE = 7
) (
    input  logic [HALF_W-1:0]    l_i,
    input  logic [HALF_W-1:0]    r_i,
    input  logic [NR*HALF_W-1:0] keys_i,
    output logic [HALF_W-1:0]    l_o,
    output logic [HALF_W-1:0]    r_o
);
    logic [HALF_W-1:0] l_c [NR+1];
    logic [HALF_W-1:0] r_c [NR+1];

    assign l_c[0] = l_i;
    assign r_c[0] = r_i;

    for (genvar i = 0; i < NR; i++) begin : g_round
        logic [HALF_W-1:0] f_w;
        lac_round_fn #(
            .HALF_W (HALF_W),
            .STRIDE (STRIDE)
        ) u_fn (
            .half_i (r_c[i]),
            .rkey_i (keys_i[i*HALF_W +: HALF_W]),
            .mix_o  (f_w)
        );
        assign l_c[i+1] = r_c[i];
        assign r_c[i+1] = l_c[i] ^ f_w;
    end

    assign l_o = l_c[NR];
    assign r_o = r_c[NR];

endmodule

// File: rtl/lac_addr_cipher.sv
module lac_addr_cipher #(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned KEY_W  = 80,
    parameter int unsigned ROUNDS = 4,
    parameter int unsigned STRIDE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_decrypt,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int unsigned HALF_W = ADDR_W / 2;
    localparam int unsigned RPS    = ROUNDS / 2;
    localparam int unsigned SKEY_W = RPS * HALF_W;

    typedef struct packed {
        logic              s1_vld;
        logic [HALF_W-1:0] s1_l;
        logic [HALF_W-1:0] s1_r;
        logic [SKEY_W-1:0] s1_keys;
        logic              o_vld;
        logic [ADDR_W-1:0] o_addr;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // round-key schedule, reversed for decryption
    logic [HALF_W-1:0] sched_w [ROUNDS];
    logic [SKEY_W-1:0] k1_w, k2_w;

    always_comb begin
        for (int i = 0; i < ROUNDS; i++) begin
            sched_w[i] = in_decrypt ? in_key[(ROUNDS-1-i)*HALF_W +: HALF_W]
                                    : in_key[i*HALF_W +: HALF_W];
        end
        for (int j = 0; j < RPS; j++) begin
            k1_w[j*HALF_W +: HALF_W] = sched_w[j];
            k2_w[j*HALF_W +: HALF_W] = sched_w[RPS + j];
        end
    end

    logic [HALF_W-1:0] a_l, a_r, b_l, b_r;

    lac_stage #(.HALF_W(HALF_W), .NR(RPS), .STRIDE(STRIDE)) u_front (
        .l_i    (in_addr[ADDR_W-1:HALF_W]),
        .r_i    (in_addr[HALF_W-1:0]),
        .keys_i (k1_w),
        .l_o    (a_l),
        .r_o    (a_r)
    );

    lac_stage #(.HALF_W(HALF_W), .NR(ROUNDS-RPS), .STRIDE(STRIDE)) u_back (
        .l_i    (pipe_q.s1_l),
        .r_i    (pipe_q.s1_r),
        .keys_i (pipe_q.s1_keys),
        .l_o    (b_l),
        .r_o    (b_r)
    );

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1_vld = in_valid;
        if (in_valid) begin
            pipe_d.s1_l    = a_l;
            pipe_d.s1_r    = a_r;
            pipe_d.s1_keys = k2_w;
        end
        pipe_d.o_vld = pipe_q.s1_vld;
        if (pipe_q.s1_vld) begin
            pipe_d.o_addr = {b_r, b_l};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.o_vld;
    assign out_addr  = pipe_q.o_addr;

    // R1: reset clears the result port
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_addr == '0));

    // R2: each accepted address emerges exactly two edges later
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2: no result without a matching input
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R7: result held while no new beat completes
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.s1_vld |=> $stable(out_addr));

    // R3: a completed result is fully defined
    assert_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_addr));

endmodule

// File: tb/tb_lac_addr_cipher.sv
module tb_lac_addr_cipher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_decrypt = 1'b0;
    logic [79:0] in_key = '0;
    logic [39:0] in_addr = '0;
    logic        out_valid;
    logic [39:0] out_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    lac_addr_cipher dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_decrypt (in_decrypt),
        .in_key     (in_key),
        .in_addr    (in_addr),
        .out_valid  (out_valid),
        .out_addr   (out_addr)
    );

    // behavioural model of the cipher from R3/R4/R5
    function automatic logic [3:0] tsub(input logic [3:0] v);
        logic [3:0] t [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                               4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};
        return t[v];
    endfunction

    function automatic logic [39:0] model(input logic [39:0] x, input logic [79:0] k,
                                          input logic dec);
        logic [19:0] l, r, s, p, nr;
        int idx;
        l = x[39:20];
        r = x[19:0];
        for (int i = 0; i < 4; i++) begin
            idx = dec ? 3 - i : i;
            for (int n = 0; n < 5; n++) s[4*n +: 4] = tsub(r[4*n +: 4]);
            for (int b = 0; b < 20; b++) p[b] = s[(7*b) % 20];
            nr = l ^ p ^ k[20*idx +: 20];
            l = r;
            r = nr;
        end
        return {r, l};
    endfunction

    function automatic logic [39:0] rnd40();
        logic [63:0] w;
        w = {$urandom(), $urandom()};
        return w[39:0];
    endfunction

    function automatic logic [79:0] rnd80();
        logic [95:0] w;
        w = {$urandom(), $urandom(), $urandom()};
        return w[79:0];
    endfunction

    // cycle model: two-deep delay of expected results
    logic        m1_v, mo_v, m1_d, mo_d;
    logic [39:0] m1_a, mo_a;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1_v <= 1'b0; m1_a <= '0; m1_d <= 1'b0;
            mo_v <= 1'b0; mo_a <= '0; mo_d <= 1'b0;
        end else begin
            m1_v <= in_valid;
            if (in_valid) begin
                m1_a <= model(in_addr, in_key, in_decrypt);
                m1_d <= in_decrypt;
            end
            mo_v <= m1_v;
            if (m1_v) begin
                mo_a <= m1_a;
                mo_d <= m1_d;
            end
        end
    end

    logic [39:0] capq[$];

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare();
        if (!rst_n) begin
            check("R1 valid", {39'b0, out_valid}, 40'b0);
            check("R1 addr", out_addr, 40'b0);
        end else begin
            check("R2 valid", {39'b0, out_valid}, {39'b0, mo_v});
            if (mo_v) begin
                if (mo_d) check("R5 R6 R4 decrypt data", out_addr, mo_a);
                else      check("R3 R6 R4 encrypt data", out_addr, mo_a);
            end else begin
                check("R7 held addr", out_addr, mo_a);
            end
            if (out_valid) capq.push_back(out_addr);
        end
    endtask

    task automatic step(input logic v, input logic d, input logic [79:0] k,
                        input logic [39:0] a);
        @(negedge clk);
        cyc++;
        compare();
        in_valid   = v;
        in_decrypt = d;
        in_key     = k;
        in_addr    = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, $urandom_range(1), rnd80(), rnd40());
    endtask

    initial begin
        int cnt;
        cnt = 0;
        while (cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cnt);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [39:0] orig [16];
        logic [39:0] encv [16];
        logic [79:0] key;

        // R1: reset phase
        idle(4);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // R3 R4: corner vectors with zero and all-ones keys
        step(1'b1, 1'b0, '0, '0);
        step(1'b1, 1'b0, '1, '0);
        step(1'b1, 1'b0, '0, '1);
        step(1'b1, 1'b1, '0, '0);
        step(1'b1, 1'b0, 80'h0000F_0000A_00005_00003, 40'h80000_00001);
        idle(4);

        // R5: round trip with one key
        key = rnd80();
        capq.delete();
        for (int i = 0; i < 16; i++) begin
            orig[i] = rnd40();
            step(1'b1, 1'b0, key, orig[i]);
        end
        idle(3);
        for (int i = 0; i < 16; i++) encv[i] = (i < capq.size()) ? capq[i] : 'x;
        capq.delete();
        for (int i = 0; i < 16; i++) step(1'b1, 1'b1, key, encv[i]);
        idle(3);
        for (int i = 0; i < 16; i++)
            check("R5 round trip", (i < capq.size()) ? capq[i] : 'x, orig[i]);

        // R6 R2 R7: random valid, key and direction changing every cycle
        for (int i = 0; i < 400; i++)
            step($urandom_range(1), $urandom_range(1), rnd80(), rnd40());
        idle(3);

        // R1: reset mid-stream clears the outputs
        step(1'b1, 1'b0, rnd80(), rnd40());
        step(1'b1, 1'b0, rnd80(), rnd40());
        rst_n = 1'b0;
        idle(2);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule